// File: doc/BRIEF.md
# Configurable Register Macrocell

A single storage cell whose data input is a sum-of-products term and whose output can be registered, latched or passed straight through. Static configuration inputs choose the operating mode (synchronous or asynchronous), the storage kind (D register, T register, transparent latch or bypass) and the active polarity of the clock edge or latch enable. The mode only decides where the clock and the initialization come from. It has no effect on the data path.

In synchronous mode the cell clocks from one of four clocks shared across its block. It initializes from two block-wide terms, one reset and one preset, and a per-cell swap bit exchanges their roles. In asynchronous mode the cell clocks from its own product-term signal and has one private initialization term, configured to act as either reset or preset. The swap bit also selects the power-up value: 0 normally, 1 when swapped. Reset always wins over preset.

All cell inputs are sampled on a fast system clock `clk`. An active transition of the selected clock is seen when two consecutive samples differ in the active direction. The stored value then appears on `q_out` after that `clk` edge. Reset, preset and the power-up reset `rst_n` also act on `clk` edges.

Top module: `cfg_macrocell`

## Requirements
- R1: While `rst_n` is low, each `clk` edge loads the power-up value into the cell: 0 when `cfg_swap`=0 and 1 when `cfg_swap`=1.
- R2: With `cfg_async`=0 and `cfg_kind`=0 (D register), the clock is `blk_clk[cfg_clk_sel]`. On the first `clk` edge that samples an active transition of that clock, `q_out` takes `d_in`. Transitions on the other block clocks, and a level that stays constant, leave `q_out` unchanged.
- R3: With `cfg_async`=1 the clock is `pt_clk`, and the block clocks have no effect.
- R4: With `cfg_pol`=0 the active edge is rising and the latch enable is active high. With `cfg_pol`=1 the active edge is falling and the enable is active low. This applies in both modes.
- R5: With `cfg_kind`=1 (T register), an active clock transition inverts `q_out` when `d_in`=1 and holds it when `d_in`=0.
- R6: With `cfg_kind`=2 (latch), `q_out` follows `d_in` at once while the enable is active. While the enable is inactive, `q_out` holds the value sampled on the last `clk` edge at which the enable was active.
- R7: With `cfg_kind`=3 (bypass), `q_out` equals `d_in` with no clock involved, in either mode.
- R8: In synchronous mode with `cfg_swap`=0, `blk_rst` clears the cell and `blk_pre` sets it on the next `clk` edge. With `cfg_swap`=1, `blk_pre` clears the cell and `blk_rst` sets it.
- R9: In asynchronous mode, `pt_init` clears the cell when `cfg_init_pre`=0 and sets it when `cfg_init_pre`=1. The block terms `blk_rst` and `blk_pre` have no effect.
- R10: When the active reset and the active preset are asserted together, the cell is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous |
| cfg_async | input | 1 | 1 selects asynchronous mode |
| cfg_kind | input | 2 | 0 D register, 1 T register, 2 latch, 3 bypass |
| cfg_pol | input | 1 | Clock edge / enable polarity (1 inverts) |
| cfg_clk_sel | input | 2 | Block clock select in synchronous mode |
| cfg_swap | input | 1 | Exchanges block reset/preset roles and the power-up value |
| cfg_init_pre | input | 1 | Asynchronous mode: private term acts as preset (1) or reset (0) |
| blk_clk | input | 4 | Shared block clocks |
| blk_rst | input | 1 | Block-wide reset term |
| blk_pre | input | 1 | Block-wide preset term |
| pt_clk | input | 1 | Private product-term clock |
| pt_init | input | 1 | Private initialization term |
| d_in | input | 1 | Sum-of-products data input |
| q_out | output | 1 | Cell output |

## Verification
The assertions assume that the configuration inputs are static while `rst_n` is high. They also assume that the cell inputs change only between `clk` edges, so that each selected-clock transition and each initialization pulse is sampled once. The bench changes configuration only inside a reset sequence. It drives every input one time unit after a rising `clk` edge and samples there, and it holds `d_in` steady across each enable or clock transition it checks.

// File: rtl/cfg_macrocell.sv
module cfg_macrocell #(
  parameter int NCLK = 4,
  localparam int SELW = $clog2(NCLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_async,
  input  logic [1:0]      cfg_kind,
  input  logic            cfg_pol,
  input  logic [SELW-1:0] cfg_clk_sel,
  input  logic            cfg_swap,
  input  logic            cfg_init_pre,
  input  logic [NCLK-1:0] blk_clk,
  input  logic            blk_rst,
  input  logic            blk_pre,
  input  logic            pt_clk,
  input  logic            pt_init,
  input  logic            d_in,
  output logic            q_out
);
  localparam logic [1:0] K_DREG  = 2'd0;
  localparam logic [1:0] K_TREG  = 2'd1;
  localparam logic [1:0] K_LATCH = 2'd2;
  localparam logic [1:0] K_BYP   = 2'd3;

  logic ck_act, ck_q, hit, r_eff, p_eff, q_st, nxt;

  assign ck_act = (cfg_async ? pt_clk : blk_clk[cfg_clk_sel]) ^ cfg_pol;
  assign hit    = ck_act & ~ck_q;

  assign r_eff = cfg_async ? (pt_init & ~cfg_init_pre)
                           : (cfg_swap ? blk_pre : blk_rst);
  assign p_eff = cfg_async ? (pt_init & cfg_init_pre)
                           : (cfg_swap ? blk_rst : blk_pre);

  always_comb begin
    nxt = q_st;
    if (r_eff)      nxt = 1'b0;
    else if (p_eff) nxt = 1'b1;
    else begin
      case (cfg_kind)
        K_DREG:  if (hit) nxt = d_in;
        K_TREG:  if (hit && d_in) nxt = ~q_st;
        K_LATCH: if (ck_act) nxt = d_in;
        default: nxt = q_st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    ck_q <= ck_act;
    if (!rst_n) q_st <= cfg_swap;
    else        q_st <= nxt;
  end

  always_comb begin
    if (cfg_kind == K_BYP)
      q_out = d_in;
    else if (cfg_kind == K_LATCH && ck_act && rst_n && !r_eff && !p_eff)
      q_out = d_in;
    else
      q_out = q_st;
  end

  AST_POWERUP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_st == cfg_swap)); // R1
  AST_D_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == K_DREG && !hit && !r_eff && !p_eff) |=> $stable(q_st)); // R2
  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == K_TREG && hit && d_in && !r_eff && !p_eff) |=> (q_st != $past(q_st))); // R5
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_eff && !r_eff) |=> q_st); // R8
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    r_eff |=> !q_st); // R10
endmodule

// File: tb/sim_cfg_macrocell.sv
module sim_cfg_macrocell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_async = 1'b0, cfg_pol = 1'b0, cfg_swap = 1'b0, cfg_init_pre = 1'b0;
  logic [1:0] cfg_kind = 2'd0, cfg_clk_sel = 2'd0;
  logic [3:0] blk_clk = 4'd0;
  logic blk_rst = 1'b0, blk_pre = 1'b0, pt_clk = 1'b0, pt_init = 1'b0, d_in = 1'b0;
  logic q;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_macrocell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_kind(cfg_kind),
    .cfg_pol(cfg_pol), .cfg_clk_sel(cfg_clk_sel), .cfg_swap(cfg_swap),
    .cfg_init_pre(cfg_init_pre), .blk_clk(blk_clk), .blk_rst(blk_rst),
    .blk_pre(blk_pre), .pt_clk(pt_clk), .pt_init(pt_init), .d_in(d_in), .q_out(q)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q_out=%b expected %b", req, q, exp);
    end
  endtask

  task automatic clr_in();
    blk_clk = 4'd0; blk_rst = 0; blk_pre = 0; pt_clk = 0; pt_init = 0; d_in = 0;
  endtask

  task automatic do_reset(input logic sw);
    rst_n = 0; cfg_swap = sw;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic t_powerup();
    clr_in(); cfg_async = 0; cfg_kind = 0; cfg_pol = 0;
    rst_n = 0; cfg_swap = 0; tick(); tick();
    chk("R1 power-up unswapped", 1'b0);
    cfg_swap = 1; tick();
    chk("R1 power-up swapped", 1'b1);
    rst_n = 1; tick();
    chk("R1 value held after release", 1'b1);
  endtask

  task automatic t_sync_d();
    clr_in(); cfg_async = 0; cfg_kind = 0; cfg_pol = 0; cfg_clk_sel = 2;
    do_reset(0);
    d_in = 1; blk_clk[1] = 1; tick();
    chk("R2 unselected clock ignored", 1'b0);
    blk_clk[2] = 1; tick();
    chk("R2 capture on selected rising edge", 1'b1);
    d_in = 0; tick(); tick();
    chk("R2 no capture while clock level constant", 1'b1);
    blk_clk[2] = 0; tick();
    chk("R2 no capture on falling edge", 1'b1);
    blk_clk[2] = 1; tick();
    chk("R2 capture zero on next rising edge", 1'b0);
  endtask

  task automatic t_pol();
    clr_in(); cfg_async = 0; cfg_kind = 0; cfg_pol = 1; cfg_clk_sel = 0;
    blk_clk[0] = 1;
    do_reset(0);
    d_in = 1; tick();
    chk("R4 idle high clock, no capture", 1'b0);
    blk_clk[0] = 0; tick();
    chk("R4 capture on falling edge when inverted", 1'b1);
    d_in = 0; blk_clk[0] = 1; tick();
    chk("R4 rising edge ignored when inverted", 1'b1);
  endtask

  task automatic t_async();
    clr_in(); cfg_async = 1; cfg_kind = 0; cfg_pol = 0; cfg_clk_sel = 0;
    do_reset(0);
    d_in = 1; blk_clk = 4'hF; tick();
    chk("R3 block clocks ignored in async mode", 1'b0);
    pt_clk = 1; tick();
    chk("R3 capture on product-term clock", 1'b1);
    cfg_pol = 1; clr_in(); pt_clk = 1; do_reset(0);
    d_in = 1; pt_clk = 0; tick();
    chk("R4 async inverted product-term clock", 1'b1);
  endtask

  task automatic t_toggle();
    clr_in(); cfg_async = 0; cfg_kind = 1; cfg_pol = 0; cfg_clk_sel = 0;
    do_reset(0);
    d_in = 1; blk_clk[0] = 1; tick();
    chk("R5 toggle to 1", 1'b1);
    blk_clk[0] = 0; tick();
    blk_clk[0] = 1; tick();
    chk("R5 toggle to 0", 1'b0);
    blk_clk[0] = 0; tick();
    d_in = 0; blk_clk[0] = 1; tick();
    chk("R5 hold when T=0", 1'b0);
  endtask

  task automatic t_latch();
    clr_in(); cfg_async = 0; cfg_kind = 2; cfg_pol = 0; cfg_clk_sel = 3;
    do_reset(0);
    d_in = 1; #1;
    chk("R6 closed latch holds", 1'b0);
    blk_clk[3] = 1; #1;
    chk("R6 transparent follows 1", 1'b1);
    d_in = 0; #1;
    chk("R6 transparent follows 0", 1'b0);
    d_in = 1; tick();
    blk_clk[3] = 0; tick();
    d_in = 0; tick();
    chk("R6 closed latch keeps last value", 1'b1);
    cfg_pol = 1; clr_in(); blk_clk[3] = 1; do_reset(0);
    d_in = 1; #1;
    chk("R4 active-low enable closed", 1'b0);
    blk_clk[3] = 0; #1;
    chk("R4 active-low enable transparent", 1'b1);
  endtask

  task automatic t_bypass();
    clr_in(); cfg_async = 0; cfg_kind = 3; cfg_pol = 0;
    do_reset(0);
    d_in = 1; #1;
    chk("R7 bypass sync follows 1", 1'b1);
    d_in = 0; #1;
    chk("R7 bypass sync follows 0", 1'b0);
    cfg_async = 1; do_reset(0);
    d_in = 1; #1;
    chk("R7 bypass async follows 1", 1'b1);
  endtask

  task automatic t_sync_init();
    clr_in(); cfg_async = 0; cfg_kind = 0; cfg_pol = 0;
    do_reset(0);
    blk_pre = 1; tick(); blk_pre = 0;
    chk("R8 block preset sets", 1'b1);
    blk_rst = 1; tick(); blk_rst = 0;
    chk("R8 block reset clears", 1'b0);
    do_reset(1);
    blk_pre = 1; tick(); blk_pre = 0;
    chk("R8 swapped: block preset clears", 1'b0);
    blk_rst = 1; tick(); blk_rst = 0;
    chk("R8 swapped: block reset sets", 1'b1);
  endtask

  task automatic t_async_init();
    clr_in(); cfg_async = 1; cfg_kind = 0; cfg_pol = 0; cfg_init_pre = 0;
    do_reset(1);
    pt_init = 1; tick(); pt_init = 0;
    chk("R9 private term as reset", 1'b0);
    blk_pre = 1; tick(); blk_pre = 0;
    chk("R9 block preset ignored in async mode", 1'b0);
    cfg_init_pre = 1; do_reset(0);
    pt_init = 1; tick(); pt_init = 0;
    chk("R9 private term as preset", 1'b1);
    blk_rst = 1; tick(); blk_rst = 0;
    chk("R9 block reset ignored in async mode", 1'b1);
  endtask

  task automatic t_dominance();
    clr_in(); cfg_async = 0; cfg_kind = 0; cfg_pol = 0;
    do_reset(1);
    blk_rst = 1; blk_pre = 1; tick();
    chk("R10 both asserted, swapped, clears", 1'b0);
    clr_in(); do_reset(0);
    blk_pre = 1; tick();
    blk_rst = 1; tick();
    chk("R10 both asserted clears", 1'b0);
    clr_in();
  endtask

  initial begin
    t_powerup();
    t_sync_d();
    t_pol();
    t_async();
    t_toggle();
    t_latch();
    t_bypass();
    t_sync_init();
    t_async_init();
    t_dominance();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule